// File: doc/BRIEF.md
# One-Shot Down-Counter Bank with Shared Reload

The block holds eight 16-bit one-shot down-counters and a single 16-bit reload value that they all share. Each counter is either idle or running. A running counter counts down by one on every cycle in which the count tick is high. When it reaches zero it stops by itself. Each counter drives one pulse output, which is high for as long as the counter runs.

A counter can be started in two ways. Software can start it by writing its bit in the start register. A compare-match strobe from a linked timer channel can also start it, if the counter's link bit is set. The shared reload value is copied into a counter only in one case: the strobe starts it while its reload enable is set. A software start never reloads. A strobe that arrives while the counter is already running changes nothing.

All registers sit behind a word-wide write port and a combinational read port. Writes take effect only when marked as full 16-bit word accesses. A standby input clears the reload value and holds it at zero.

Top module: `oneshot_reload_bank`

## Requirements
- R1: After reset every register reads zero, every counter is idle and every pulse output is low.
- R2: Address 0 holds the 16-bit reload value. A word write to it is read back unchanged. A write with `reg_word_i` low changes no register.
- R3: While `standby_i` is high the reload value becomes zero and stays zero, and word writes to it are discarded.
- R4: On a strobe edge, an idle counter whose link bit (address 2, bit i) and reload enable bit (address 1, bit i) are both set becomes running and takes the reload value held before that edge.
- R5: On a strobe edge, an idle linked counter whose reload enable bit is clear becomes running and keeps its current count.
- R6: Writing 1 to bit i of the start register (address 3) starts idle counter i without a reload, even when its reload enable is set. Zero bits have no effect, and address 3 reads back the running flags.
- R7: A strobe that arrives while a counter runs neither reloads nor restarts that counter.
- R8: While running, a counter decrements on each cycle with `tick_i` high. The decrement that reaches zero also ends the run. A counter that runs with a count of zero stops at the next edge. No decrement happens on the edge that starts a counter. Counter i is read at address 8+i.
- R9: `pulse_o[i]` is high exactly while counter i is running.
- R10: When a strobe reload and a software write to the same counter's address occur in the same cycle, the reload value is the one stored.
- R11: Counters whose link bit is clear ignore the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Standby request; clears the reload value |
| reg_wr_i | input | 1 | Register write strobe |
| reg_word_i | input | 1 | Marks the access as a full word |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| cmp_strobe_i | input | 1 | Compare-match strobe from the linked channel |
| tick_i | input | 1 | Count tick |
| pulse_o | output | 8 | Per-counter one-shot pulse |

## Verification
The start paths are driven with a linked strobe under reload enabled and disabled, with a software start on a reload-enabled counter, and with a strobe aimed at counters that are already running. Together these separate a correct reload from one that fires on every start or on every strobe. Count-down is driven with ticks that are gapped, back to back, and random, which exposes off-by-one stops and decrements on the start edge. A strobe reload that lands together with a software write to the same counter fixes the write priority. A long random phase mixes strobes, standby, byte writes and word writes. It is compared cycle by cycle against a behavioural model.

// File: rtl/oneshot_reload_bank.sv
module oneshot_reload_bank #(
  parameter int NCNT = 8,
  parameter int W    = 16,
  parameter int AW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            standby_i,
  input  logic            reg_wr_i,
  input  logic            reg_word_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [W-1:0]    reg_wdata_i,
  output logic [W-1:0]    reg_rdata_o,
  input  logic            cmp_strobe_i,
  input  logic            tick_i,
  output logic [NCNT-1:0] pulse_o
);
  localparam logic [AW-1:0] A_RELOAD = AW'(0);
  localparam logic [AW-1:0] A_RLDEN  = AW'(1);
  localparam logic [AW-1:0] A_LINK   = AW'(2);
  localparam logic [AW-1:0] A_START  = AW'(3);
  localparam int            CNT_BASE = 1 << (AW - 1);

  logic [W-1:0]            reload_q;
  logic [NCNT-1:0]         rld_en_q, link_q, run_q;
  logic [NCNT-1:0][W-1:0]  cnt_q;

  wire wr_ok = reg_wr_i & reg_word_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                 reload_q <= '0;
    else if (standby_i)                          reload_q <= '0;
    else if (wr_ok && reg_addr_i == A_RELOAD)    reload_q <= reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rld_en_q <= '0;
      link_q   <= '0;
    end else if (wr_ok) begin
      if (reg_addr_i == A_RLDEN) rld_en_q <= reg_wdata_i[NCNT-1:0];
      if (reg_addr_i == A_LINK)  link_q   <= reg_wdata_i[NCNT-1:0];
    end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    wire strb_go = cmp_strobe_i & link_q[i] & ~run_q[i];
    wire sw_go   = wr_ok & (reg_addr_i == A_START) & reg_wdata_i[i] & ~run_q[i];
    wire do_load = strb_go & rld_en_q[i];
    wire cnt_wr  = wr_ok & (reg_addr_i == AW'(CNT_BASE + i));
    wire at_zero = cnt_q[i] == '0;
    wire at_one  = cnt_q[i] == W'(1);

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                       run_q[i] <= 1'b0;
      else if (strb_go | sw_go)                          run_q[i] <= 1'b1;
      else if (run_q[i] && (at_zero || (tick_i && at_one))) run_q[i] <= 1'b0;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                              cnt_q[i] <= '0;
      else if (do_load)                         cnt_q[i] <= reload_q;
      else if (cnt_wr)                          cnt_q[i] <= reg_wdata_i;
      else if (run_q[i] && tick_i && !at_zero)  cnt_q[i] <= cnt_q[i] - W'(1);
  end

  assign pulse_o = run_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_RELOAD: reg_rdata_o = reload_q;
      A_RLDEN:  reg_rdata_o = W'(rld_en_q);
      A_LINK:   reg_rdata_o = W'(link_q);
      A_START:  reg_rdata_o = W'(run_q);
      default:
        for (int k = 0; k < NCNT; k++)
          if (reg_addr_i == AW'(CNT_BASE + k)) reg_rdata_o = cnt_q[k];
    endcase
  end
endmodule

// File: rtl/oneshot_reload_bank_chk.sv
module oneshot_reload_bank_chk #(
  parameter int NCNT = 8,
  parameter int W    = 16,
  parameter int AW   = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   standby_i,
  input logic                   reg_wr_i,
  input logic                   reg_word_i,
  input logic [AW-1:0]          reg_addr_i,
  input logic [W-1:0]           reg_wdata_i,
  input logic                   cmp_strobe_i,
  input logic                   tick_i,
  input logic [NCNT-1:0]        pulse_o,
  input logic [W-1:0]           reload_q,
  input logic [NCNT-1:0]        rld_en_q,
  input logic [NCNT-1:0]        link_q,
  input logic [NCNT-1:0][W-1:0] cnt_q
);
  localparam int CB = 1 << (AW - 1);
  wire wok = reg_wr_i & reg_word_i;

  AST_BYTE_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && !reg_word_i && !standby_i |=> $stable(reload_q)); // R2
  AST_STANDBY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> reload_q == '0); // R3

  for (genvar i = 0; i < NCNT; i++) begin : g_a
    wire cw = wok && reg_addr_i == AW'(CB + i);
    AST_STROBE_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_strobe_i && link_q[i] && rld_en_q[i] && !pulse_o[i]
      |=> pulse_o[i] && cnt_q[i] == $past(reload_q)); // R4
    AST_SW_START_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wok && reg_addr_i == AW'(3) && reg_wdata_i[i] && !pulse_o[i]
      && !(cmp_strobe_i && link_q[i]) && !cw
      |=> pulse_o[i] && cnt_q[i] == $past(cnt_q[i])); // R6
    AST_RUNNING_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[i] && !cw
      |=> cnt_q[i] == $past(cnt_q[i]) || cnt_q[i] == $past(cnt_q[i]) - W'(1)); // R7
    AST_STOP_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[i] && (cnt_q[i] == '0 || (tick_i && cnt_q[i] == W'(1)))
      |=> !pulse_o[i]); // R8
  end
endmodule

bind oneshot_reload_bank oneshot_reload_bank_chk #(.NCNT(NCNT), .W(W), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i), .reg_wr_i(reg_wr_i),
  .reg_word_i(reg_word_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .cmp_strobe_i(cmp_strobe_i), .tick_i(tick_i), .pulse_o(pulse_o),
  .reload_q(reload_q), .rld_en_q(rld_en_q), .link_q(link_q), .cnt_q(cnt_q));

// File: tb/oneshot_reload_bank_tb.sv
module oneshot_reload_bank_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        standby = 0, reg_wr = 0, reg_word = 0, strobe = 0, tick = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [7:0]  pulse;

  oneshot_reload_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .reg_wr_i(reg_wr),
    .reg_word_i(reg_word), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .cmp_strobe_i(strobe), .tick_i(tick), .pulse_o(pulse));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [15:0] m_rl = 0;
  logic [7:0]  m_en = 0, m_link = 0, m_run = 0;
  logic [15:0] m_cnt [8];
  initial for (int i = 0; i < 8; i++) m_cnt[i] = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return m_rl;
      4'd1: return {8'h0, m_en};
      4'd2: return {8'h0, m_link};
      4'd3: return {8'h0, m_run};
      default: return a >= 4'd8 ? m_cnt[a - 4'd8] : 16'h0;
    endcase
  endfunction

  task automatic model_step();
    logic        wok, sg, ss, cw;
    logic [15:0] c;
    if (!rst_n) begin
      m_rl = 0; m_en = 0; m_link = 0; m_run = 0;
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
      return;
    end
    wok = reg_wr && reg_word;
    for (int i = 0; i < 8; i++) begin
      sg = strobe && m_link[i] && !m_run[i];
      ss = wok && reg_addr == 4'd3 && reg_wdata[i] && !m_run[i];
      cw = wok && reg_addr == 4'(8 + i);
      c  = m_cnt[i];
      if (sg) begin
        m_run[i] = 1;
        if (m_en[i]) m_cnt[i] = m_rl;
        else if (cw) m_cnt[i] = reg_wdata;
      end else begin
        if (m_run[i]) begin
          if (c == 0) m_run[i] = 0;
          else if (tick) begin
            if (c == 1) m_run[i] = 0;
            m_cnt[i] = c - 1;
          end
        end else if (ss) m_run[i] = 1;
        if (cw) m_cnt[i] = reg_wdata;
      end
    end
    if (wok && reg_addr == 4'd1) m_en = reg_wdata[7:0];
    if (wok && reg_addr == 4'd2) m_link = reg_wdata[7:0];
    if (standby) m_rl = 0;
    else if (wok && reg_addr == 4'd0) m_rl = reg_wdata;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R9 pulse vs model", pulse, m_run);
    chk("R8 read vs model", reg_rdata, m_read(reg_addr));
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d, logic word);
    reg_wr = 1; reg_word = word; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 0; reg_word = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [15:0] exp, string req);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    rd(0, 16'h0, "R1 reload after reset");
    rd(3, 16'h0, "R1 run flags after reset");
    chk("R1 pulses after reset", pulse, 8'h0);
    // R2 word and byte writes
    wr(0, 16'h0005, 1);
    rd(0, 16'h0005, "R2 word write");
    wr(0, 16'hFFFF, 0);
    rd(0, 16'h0005, "R2 byte write ignored");
    // R3 standby
    standby = 1; wr(0, 16'h1234, 1); standby = 0;
    rd(0, 16'h0000, "R3 standby clears and blocks");
    wr(0, 16'h0003, 1);
    wr(2, 16'h000F, 1);
    wr(1, 16'h0005, 1);
    wr(9, 16'h0007, 1);
    strobe = 1; cyc(); strobe = 0;
    rd(8, 16'h0003, "R4 reload on linked strobe");
    rd(9, 16'h0007, "R5 no reload when disabled");
    chk("R11 unlinked stay idle", pulse[7:4], 4'h0);
    chk("R4 started counters", pulse[2:0], 3'b111);
    tick = 1; cyc(); tick = 0;
    rd(8, 16'h0002, "R8 decrement");
    wr(0, 16'h0009, 1);
    strobe = 1; cyc(); strobe = 0;
    rd(8, 16'h0002, "R7 running counter not reloaded");
    cyc();
    tick = 1; cyc(); cyc(); tick = 0;
    rd(8, 16'h0000, "R8 reaches zero");
    chk("R8 stop at zero", pulse[0], 1'b0);
    wr(8, 16'h0004, 1);
    wr(3, 16'h0001, 1);
    rd(8, 16'h0004, "R6 software start no reload");
    chk("R6 software start runs", pulse[0], 1'b1);
    reg_wr = 1; reg_word = 1; reg_addr = 10; reg_wdata = 16'h0055; strobe = 1;
    cyc();
    reg_wr = 0; reg_word = 0; strobe = 0;
    rd(10, 16'h0009, "R10 reload beats write");
    for (int n = 0; n < 600; n++) begin
      tick    = $urandom_range(0, 2) != 0;
      strobe  = $urandom_range(0, 9) == 0;
      standby = $urandom_range(0, 40) == 0;
      reg_wr  = $urandom_range(0, 3) == 0;
      reg_word = $urandom_range(0, 4) != 0;
      reg_addr = 4'($urandom_range(0, 15));
      reg_wdata = (reg_addr >= 8) ? 16'($urandom_range(0, 12)) : 16'($urandom);
      cyc();
    end
    tick = 0; strobe = 0; standby = 0; reg_wr = 0; reg_word = 0;
    cyc();
    done = 1;
    summary();
    $finish;
  end
endmodule